// File: doc/BRIEF.md
# Cache maintenance controller

This block runs maintenance operations on the tag and data storage of a small set-associative cache. Software starts an operation by writing to a task register. Seven tasks are available. Invalidate, clean and flush each come in a whole-cache form and a single-line form, and erase acts on the whole cache. The single-line forms act on the line that covers the address held in a line-address register. Software can read and write that register.

A whole-cache task walks the storage one set per clock cycle and treats every way of that set together. A single-line task spends one cycle on a lookup in the addressed set. It changes only a way that holds a valid line with a matching tag. While a task runs, the busy output is high. An erase also sets a sticky done flag when it finishes, and software clears that flag by writing 0 to it.

The storage is a register array inside the block. Each line holds four data units, each with its own valid bit, plus a whole-line valid bit and two dirty bits. A fill port loads unit data so that the cache contents can be built up, and a probe port reads any line back.

Top module: `cache_maint_ctrl`

## Requirements
- R1: After reset, busy and the erase-done flag are 0, the line-address register reads 0, and every line reads back with its tag, valid bit, unit valid bits, dirty bits and data all at zero.
- R2: A task starts only when the value written to its task register is exactly 1. Any other value written to a task register starts nothing. A write to an address with no register starts nothing.
- R3: A whole-cache task holds busy high for exactly SETS cycles, beginning in the cycle after the write. A single-line task holds busy high for exactly one cycle.
- R4: While busy is high, the block ignores task writes, line-address writes and fill requests.
- R5: Invalidate clears the line valid bit and all four unit valid bits. The tag, the dirty bits and the data are kept.
- R6: Clean clears both dirty bits of a line and keeps the line valid. A clean does not touch the erase-done flag.
- R7: Flush clears the valid bits and the dirty bits of a line, which amounts to a clean followed by an invalidate.
- R8: Erase sets the tag, valid bits, dirty bits and data of every line to zero. The erase-done flag goes to 1 in the same cycle that busy falls. The flag stays at 1 until software writes 0 to its register; writing any other value leaves it at 1.
- R9: A line task selects the set from address bits [5:4] and compares address bits [15:6] with the tag of each valid way in that set. A miss completes in one cycle and leaves every line unchanged. A valid line in a different set that has the same tag is not affected.
- R10: A fill writes one data unit and sets the line valid bit and that unit's valid bit. A dirty fill of unit 0 or 1 sets dirty bit 0, and a dirty fill of unit 2 or 3 sets dirty bit 1. A fill into an invalid line, or with a tag that differs from the stored tag, first clears the other unit valid bits and both dirty bits.
- R11: Register addresses are: 0 invalidate-all, 1 invalidate-line, 2 clean-all, 3 clean-line, 4 flush-all, 5 flush-line, 6 erase, 7 line address (read and write, 16 bits), 8 erase-done flag (bit 0). All other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| busy_o | output | 1 | A maintenance task is running |
| erase_done_o | output | 1 | Sticky flag set when an erase finishes |
| fill_en_i | input | 1 | Fill request |
| fill_set_i | input | 2 | Set to fill |
| fill_way_i | input | 1 | Way to fill |
| fill_tag_i | input | 10 | Tag of the filled line |
| fill_unit_i | input | 2 | Data unit to write |
| fill_data_i | input | 32 | Data for the unit |
| fill_dirty_i | input | 1 | Mark the unit's dirty pair |
| probe_set_i | input | 2 | Set to read back |
| probe_way_i | input | 1 | Way to read back |
| probe_unit_i | input | 2 | Unit whose data is read back |
| probe_tag_o | output | 10 | Tag of the probed line |
| probe_valid_o | output | 1 | Line valid bit |
| probe_uvalid_o | output | 4 | Unit valid bits, bit n for unit n |
| probe_dirty_o | output | 2 | Dirty bits (bit 0 for units 0 and 1, bit 1 for units 2 and 3) |
| probe_data_o | output | 32 | Data of the probed unit |

## Verification
The assertions check the sequencing on every cycle. An accepted task raises busy on the next cycle. A line task drops busy one cycle later. The line address cannot change while busy is high. The done flag rises only as busy falls and stays set until software writes 0 to it. Only the bench scenarios show what each task does to the storage: which valid, dirty, tag and data bits change or survive, that misses and lines in other sets are left alone, that writes of values other than 1 are filtered out, and how fills merge units into a line.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    // Operation encoding equals register address bits [2:1]
    typedef enum logic [1:0] {
        OP_INV   = 2'd0,
        OP_CLEAN = 2'd1,
        OP_FLUSH = 2'd2,
        OP_ERASE = 2'd3
    } maint_op_e;

    localparam int UNITS = 4;

    localparam logic [3:0] RA_ERASE      = 4'd6;
    localparam logic [3:0] RA_LINE_ADDR  = 4'd7;
    localparam logic [3:0] RA_ERASE_DONE = 4'd8;
endpackage

// File: rtl/cmt_regs.sv
module cmt_regs
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [3:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              busy_i,
    input  logic              erase_fin_i,
    output logic              start_o,
    output maint_op_e         start_op_o,
    output logic              start_line_o,
    output logic [ADDR_W-1:0] line_addr_o,
    output logic              erase_done_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] laddr;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d          = r_q;
        start_o      = 1'b0;
        start_op_o   = maint_op_e'(reg_addr_i[2:1]);
        start_line_o = reg_addr_i[0];
        if (reg_wr_i && !busy_i) begin
            if (reg_addr_i == RA_LINE_ADDR) begin
                r_d.laddr = reg_wdata_i[ADDR_W-1:0];
            end
            if (reg_addr_i <= RA_ERASE && reg_wdata_i == 32'd1) begin
                start_o = 1'b1;
            end
        end
        if (reg_wr_i && reg_addr_i == RA_ERASE_DONE && reg_wdata_i == 32'd0) begin
            r_d.done = 1'b0;
        end
        // A finishing erase wins over a clear in the same cycle
        if (erase_fin_i) begin
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == RA_LINE_ADDR)       reg_rdata_o[ADDR_W-1:0] = r_q.laddr;
        else if (reg_addr_i == RA_ERASE_DONE) reg_rdata_o[0] = r_q.done;
    end

    assign line_addr_o  = r_q.laddr;
    assign erase_done_o = r_q.done;
endmodule

// File: rtl/cmt_walker.sv
module cmt_walker
    import cmt_pkg::*;
#(
    parameter int SETS  = 4,
    parameter int SET_W = 2,
    parameter int TAG_W = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  maint_op_e          start_op_i,
    input  logic               start_line_i,
    input  logic [TAG_W+SET_W-1:0] line_idx_i,
    output logic               busy_o,
    output logic               cmd_valid_o,
    output maint_op_e          cmd_op_o,
    output logic               cmd_line_o,
    output logic [SET_W-1:0]   cmd_set_o,
    output logic [TAG_W-1:0]   cmd_tag_o,
    output logic               erase_fin_o
);
    localparam logic [SET_W-1:0] LAST_SET = SET_W'(SETS - 1);

    typedef struct packed {
        logic             busy;
        maint_op_e        op;
        logic             line;
        logic [SET_W-1:0] ptr;
    } walk_t;

    walk_t w_d, w_q;
    logic  last_step;

    assign last_step = w_q.line || (w_q.ptr == LAST_SET);

    always_comb begin
        w_d = w_q;
        if (w_q.busy) begin
            if (last_step) w_d.busy = 1'b0;
            else           w_d.ptr  = w_q.ptr + SET_W'(1);
        end else if (start_i) begin
            w_d.busy = 1'b1;
            w_d.op   = start_op_i;
            w_d.line = start_line_i;
            w_d.ptr  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) w_q <= '0;
        else         w_q <= w_d;
    end

    assign busy_o      = w_q.busy;
    assign cmd_valid_o = w_q.busy;
    assign cmd_op_o    = w_q.op;
    assign cmd_line_o  = w_q.line;
    assign cmd_set_o   = w_q.line ? line_idx_i[SET_W-1:0] : w_q.ptr;
    assign cmd_tag_o   = line_idx_i[TAG_W+SET_W-1:SET_W];
    assign erase_fin_o = w_q.busy && (w_q.op == OP_ERASE) && last_step;
endmodule

// File: rtl/cmt_tag_store.sv
module cmt_tag_store
    import cmt_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 10,
    parameter int SET_W  = 2,
    parameter int WAY_W  = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_valid_i,
    input  maint_op_e         cmd_op_i,
    input  logic              cmd_line_i,
    input  logic [SET_W-1:0]  cmd_set_i,
    input  logic [TAG_W-1:0]  cmd_tag_i,
    input  logic              fill_en_i,
    input  logic [SET_W-1:0]  fill_set_i,
    input  logic [WAY_W-1:0]  fill_way_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [1:0]        fill_unit_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              fill_dirty_i,
    input  logic [SET_W-1:0]  probe_set_i,
    input  logic [WAY_W-1:0]  probe_way_i,
    input  logic [1:0]        probe_unit_i,
    output logic [TAG_W-1:0]  probe_tag_o,
    output logic              probe_valid_o,
    output logic [UNITS-1:0]  probe_uvalid_o,
    output logic [1:0]        probe_dirty_o,
    output logic [DATA_W-1:0] probe_data_o
);
    typedef struct packed {
        logic [TAG_W-1:0]              tag;
        logic                          valid;
        logic [UNITS-1:0]              uvalid;
        logic [1:0]                    dirty;
        logic [UNITS-1:0][DATA_W-1:0]  data;
    } line_t;

    line_t mem_d [SETS][WAYS];
    line_t mem_q [SETS][WAYS];
    line_t cur;
    logic  hit;

    always_comb begin
        mem_d = mem_q;
        cur   = '0;
        hit   = 1'b0;
        if (cmd_valid_i) begin
            for (int w = 0; w < WAYS; w++) begin
                cur = mem_q[cmd_set_i][w];
                hit = !cmd_line_i || (cur.valid && cur.tag == cmd_tag_i);
                if (hit) begin
                    unique case (cmd_op_i)
                        OP_INV: begin
                            cur.valid  = 1'b0;
                            cur.uvalid = '0;
                        end
                        OP_CLEAN: cur.dirty = '0;
                        OP_FLUSH: begin
                            cur.dirty  = '0;
                            cur.valid  = 1'b0;
                            cur.uvalid = '0;
                        end
                        OP_ERASE: cur = '0;
                        default: ;
                    endcase
                end
                mem_d[cmd_set_i][w] = cur;
            end
        end else if (fill_en_i) begin
            cur = mem_q[fill_set_i][fill_way_i];
            if (!cur.valid || cur.tag != fill_tag_i) begin
                cur.uvalid = '0;
                cur.dirty  = '0;
            end
            cur.tag                 = fill_tag_i;
            cur.valid               = 1'b1;
            cur.uvalid[fill_unit_i] = 1'b1;
            cur.data[fill_unit_i]   = fill_data_i;
            if (fill_dirty_i) cur.dirty[fill_unit_i[1]] = 1'b1;
            mem_d[fill_set_i][fill_way_i] = cur;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    mem_q[s][w] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    line_t pl;
    assign pl             = mem_q[probe_set_i][probe_way_i];
    assign probe_tag_o    = pl.tag;
    assign probe_valid_o  = pl.valid;
    assign probe_uvalid_o = pl.uvalid;
    assign probe_dirty_o  = pl.dirty;
    assign probe_data_o   = pl.data[probe_unit_i];
endmodule

// File: rtl/cache_maint_ctrl.sv
module cache_maint_ctrl
    import cmt_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    localparam int OFF_W = $clog2(UNITS * DATA_W / 8),
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS),
    localparam int TAG_W = ADDR_W - OFF_W - SET_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic [3:0]        reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    output logic              busy_o,
    output logic              erase_done_o,
    input  logic              fill_en_i,
    input  logic [SET_W-1:0]  fill_set_i,
    input  logic [WAY_W-1:0]  fill_way_i,
    input  logic [TAG_W-1:0]  fill_tag_i,
    input  logic [1:0]        fill_unit_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              fill_dirty_i,
    input  logic [SET_W-1:0]  probe_set_i,
    input  logic [WAY_W-1:0]  probe_way_i,
    input  logic [1:0]        probe_unit_i,
    output logic [TAG_W-1:0]  probe_tag_o,
    output logic              probe_valid_o,
    output logic [UNITS-1:0]  probe_uvalid_o,
    output logic [1:0]        probe_dirty_o,
    output logic [DATA_W-1:0] probe_data_o
);
    logic              start;
    maint_op_e         start_op;
    logic              start_line;
    logic [ADDR_W-1:0] line_addr;
    logic              erase_fin;
    logic              cmd_valid;
    maint_op_e         cmd_op;
    logic              cmd_line;
    logic [SET_W-1:0]  cmd_set;
    logic [TAG_W-1:0]  cmd_tag;

    cmt_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .reg_wr_i     (reg_wr_i),
        .reg_addr_i   (reg_addr_i),
        .reg_wdata_i  (reg_wdata_i),
        .reg_rdata_o  (reg_rdata_o),
        .busy_i       (busy_o),
        .erase_fin_i  (erase_fin),
        .start_o      (start),
        .start_op_o   (start_op),
        .start_line_o (start_line),
        .line_addr_o  (line_addr),
        .erase_done_o (erase_done_o)
    );

    cmt_walker #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) i_walker (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start),
        .start_op_i   (start_op),
        .start_line_i (start_line),
        .line_idx_i   (line_addr[ADDR_W-1:OFF_W]),
        .busy_o       (busy_o),
        .cmd_valid_o  (cmd_valid),
        .cmd_op_o     (cmd_op),
        .cmd_line_o   (cmd_line),
        .cmd_set_o    (cmd_set),
        .cmd_tag_o    (cmd_tag),
        .erase_fin_o  (erase_fin)
    );

    cmt_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .DATA_W(DATA_W),
        .TAG_W(TAG_W), .SET_W(SET_W), .WAY_W(WAY_W)
    ) i_store (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cmd_valid_i    (cmd_valid),
        .cmd_op_i       (cmd_op),
        .cmd_line_i     (cmd_line),
        .cmd_set_i      (cmd_set),
        .cmd_tag_i      (cmd_tag),
        .fill_en_i      (fill_en_i),
        .fill_set_i     (fill_set_i),
        .fill_way_i     (fill_way_i),
        .fill_tag_i     (fill_tag_i),
        .fill_unit_i    (fill_unit_i),
        .fill_data_i    (fill_data_i),
        .fill_dirty_i   (fill_dirty_i),
        .probe_set_i    (probe_set_i),
        .probe_way_i    (probe_way_i),
        .probe_unit_i   (probe_unit_i),
        .probe_tag_o    (probe_tag_o),
        .probe_valid_o  (probe_valid_o),
        .probe_uvalid_o (probe_uvalid_o),
        .probe_dirty_o  (probe_dirty_o),
        .probe_data_o   (probe_data_o)
    );
endmodule

// File: rtl/cmt_checker.sv
module cmt_checker
    import cmt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              reg_wr_i,
    input logic [3:0]        reg_addr_i,
    input logic [31:0]       reg_wdata_i,
    input logic              busy_o,
    input logic              erase_done_o,
    input logic              start,
    input logic              start_line,
    input logic              erase_fin,
    input logic [ADDR_W-1:0] line_addr
);
    // R3: an accepted task makes the block busy on the next cycle
    p_start_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> busy_o);

    // R3: a line task is busy for exactly one cycle
    p_line_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start && start_line |=> busy_o ##1 !busy_o);

    // R3: the last erase step ends the busy phase
    p_fin_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_fin |=> !busy_o);

    // R4: the line address cannot change while a task runs
    p_laddr_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(line_addr));

    // R8: done flag rises only as busy falls
    p_done_at_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(erase_done_o) |-> $fell(busy_o));

    // R8: done flag stays until software writes 0 to it
    p_done_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_done_o && !(reg_wr_i && reg_addr_i == RA_ERASE_DONE && reg_wdata_i == 32'd0)
        |=> erase_done_o);
endmodule

bind cache_maint_ctrl cmt_checker #(.ADDR_W(ADDR_W)) i_cmt_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .reg_wr_i     (reg_wr_i),
    .reg_addr_i   (reg_addr_i),
    .reg_wdata_i  (reg_wdata_i),
    .busy_o       (busy_o),
    .erase_done_o (erase_done_o),
    .start        (start),
    .start_line   (start_line),
    .erase_fin    (erase_fin),
    .line_addr    (line_addr)
);

// File: tb/test_cache_maint_ctrl.sv
module test_cache_maint_ctrl;
    localparam int SETS = 4;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [3:0]  reg_addr_i = '0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        busy_o, erase_done_o;
    logic        fill_en_i = 1'b0;
    logic [1:0]  fill_set_i = '0;
    logic        fill_way_i = 1'b0;
    logic [9:0]  fill_tag_i = '0;
    logic [1:0]  fill_unit_i = '0;
    logic [31:0] fill_data_i = '0;
    logic        fill_dirty_i = 1'b0;
    logic [1:0]  probe_set_i = '0;
    logic        probe_way_i = 1'b0;
    logic [1:0]  probe_unit_i = '0;
    logic [9:0]  probe_tag_o;
    logic        probe_valid_o;
    logic [3:0]  probe_uvalid_o;
    logic [1:0]  probe_dirty_o;
    logic [31:0] probe_data_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk_i = ~clk_i;

    cache_maint_ctrl i_cache_maint_ctrl (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkaddr(input logic [9:0] tag, input logic [1:0] set);
        return {16'h0, tag, set, 4'h0};
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_i);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk_i);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr_i = a;
        #1;
        d = reg_rdata_o;
    endtask

    task automatic fill(input logic [1:0] s, input logic w, input logic [9:0] t,
                        input logic [1:0] u, input logic [31:0] d, input logic dirty);
        @(negedge clk_i);
        fill_en_i = 1'b1; fill_set_i = s; fill_way_i = w; fill_tag_i = t;
        fill_unit_i = u; fill_data_i = d; fill_dirty_i = dirty;
        @(negedge clk_i);
        fill_en_i = 1'b0;
    endtask

    task automatic probe(input logic [1:0] s, input logic w, input logic [1:0] u);
        probe_set_i = s; probe_way_i = w; probe_unit_i = u;
        #1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 50 && busy_o; i++) @(negedge clk_i);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 busy", busy_o, 0);
        chk("R1 done", erase_done_o, 0);
        rd(4'd7, d); chk("R1 line address", d, 0);
        probe(2'd0, 1'b0, 2'd0);
        chk("R1 line", {probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o, probe_data_o}, 0);
        probe(2'd3, 1'b1, 2'd3);
        chk("R1 line", {probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o, probe_data_o}, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(4'd7, 32'h0000_1234); rd(4'd7, d); chk("R11 line address rw", d, 32'h1234);
        wr(4'd7, 32'h0001_5678); rd(4'd7, d); chk("R11 line address width", d, 32'h5678);
        rd(4'd9, d);  chk("R11 unused address", d, 0);
        rd(4'd8, d);  chk("R11 done register", d, 0);
    endtask

    task automatic t_fill();
        fill(2'd1, 1'b0, 10'd5, 2'd2, 32'hA0A0_0002, 1'b1);
        probe(2'd1, 1'b0, 2'd2);
        chk("R10 first fill", {probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o},
            {10'd5, 1'b1, 4'b0100, 2'b10});
        chk("R10 fill data", probe_data_o, 32'hA0A0_0002);
        fill(2'd1, 1'b0, 10'd5, 2'd0, 32'hB0B0_0000, 1'b0);
        probe(2'd1, 1'b0, 2'd0);
        chk("R10 merge clean unit", {probe_uvalid_o, probe_dirty_o}, {4'b0101, 2'b10});
        fill(2'd1, 1'b0, 10'd5, 2'd1, 32'hC0C0_0001, 1'b1);
        probe(2'd1, 1'b0, 2'd1);
        chk("R10 dirty pair low", {probe_uvalid_o, probe_dirty_o}, {4'b0111, 2'b11});
        fill(2'd1, 1'b0, 10'd6, 2'd3, 32'hD0D0_0003, 1'b0);
        probe(2'd1, 1'b0, 2'd3);
        chk("R10 new tag resets line", {probe_tag_o, probe_uvalid_o, probe_dirty_o, probe_data_o},
            {10'd6, 4'b1000, 2'b00, 32'hD0D0_0003});
    endtask

    task automatic t_value_filter();
        fill(2'd2, 1'b1, 10'd3, 2'd0, 32'hE, 1'b1);
        wr(4'd0, 32'd2);
        chk("R2 value 2 ignored", busy_o, 0);
        wr(4'd4, 32'h0000_0101);
        chk("R2 value 0x101 ignored", busy_o, 0);
        wr(4'd9, 32'd1);
        chk("R2 unused address", busy_o, 0);
        probe(2'd2, 1'b1, 2'd0);
        chk("R2 line untouched", {probe_valid_o, probe_dirty_o}, {1'b1, 2'b01});
    endtask

    task automatic t_line_ops();
        fill(2'd1, 1'b0, 10'd5, 2'd0, 32'h11, 1'b1);
        fill(2'd1, 1'b1, 10'd7, 2'd3, 32'h22, 1'b1);
        wr(4'd7, mkaddr(10'd5, 2'd1));
        wr(4'd3, 32'd1);
        chk("R3 line task busy", busy_o, 1);
        @(negedge clk_i);
        chk("R3 line task one cycle", busy_o, 0);
        probe(2'd1, 1'b0, 2'd0);
        chk("R6 clean line", {probe_valid_o, probe_uvalid_o, probe_dirty_o}, {1'b1, 4'b0001, 2'b00});
        probe(2'd1, 1'b1, 2'd0);
        chk("R9 other way kept", probe_dirty_o, 2'b10);
        wr(4'd7, mkaddr(10'd9, 2'd1));
        wr(4'd1, 32'd1);
        chk("R9 miss busy", busy_o, 1);
        @(negedge clk_i);
        chk("R9 miss one cycle", busy_o, 0);
        probe(2'd1, 1'b0, 2'd0); chk("R9 miss way0", probe_valid_o, 1);
        probe(2'd1, 1'b1, 2'd0); chk("R9 miss way1", probe_valid_o, 1);
        wr(4'd7, mkaddr(10'd7, 2'd0));
        wr(4'd1, 32'd1); wait_idle();
        probe(2'd1, 1'b1, 2'd0); chk("R9 other set kept", probe_valid_o, 1);
        wr(4'd7, mkaddr(10'd7, 2'd1));
        wr(4'd1, 32'd1); wait_idle();
        probe(2'd1, 1'b1, 2'd3);
        chk("R5 invalidate line", {probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o, probe_data_o},
            {10'd7, 1'b0, 4'b0000, 2'b10, 32'h22});
        probe(2'd1, 1'b0, 2'd0); chk("R9 hit only target way", probe_valid_o, 1);
        fill(2'd1, 1'b0, 10'd5, 2'd2, 32'h33, 1'b1);
        wr(4'd7, mkaddr(10'd5, 2'd1));
        wr(4'd5, 32'd1); wait_idle();
        probe(2'd1, 1'b0, 2'd0);
        chk("R7 flush line", {probe_valid_o, probe_uvalid_o, probe_dirty_o}, 0);
    endtask

    task automatic t_whole_busy();
        logic [31:0] d;
        int cnt;
        fill(2'd0, 1'b0, 10'd1, 2'd0, 32'hF, 1'b1);
        wr(4'd7, 32'h0000_0040);
        wr(4'd0, 32'd1);
        cnt = 0;
        while (busy_o && cnt < 20) begin
            cnt++;
            if (cnt == 1) begin
                fill_en_i = 1'b1; fill_set_i = 2'd3; fill_way_i = 1'b1; fill_tag_i = 10'd2;
                fill_unit_i = 2'd0; fill_dirty_i = 1'b0;
                reg_wr_i = 1'b1; reg_addr_i = 4'd7; reg_wdata_i = 32'h0ABC;
            end else if (cnt == 2) begin
                fill_en_i = 1'b0;
                reg_wr_i = 1'b1; reg_addr_i = 4'd6; reg_wdata_i = 32'd1;
            end else begin
                fill_en_i = 1'b0; reg_wr_i = 1'b0;
            end
            @(negedge clk_i);
        end
        fill_en_i = 1'b0; reg_wr_i = 1'b0;
        chk("R3 whole task busy cycles", cnt, SETS);
        probe(2'd3, 1'b1, 2'd0); chk("R4 fill ignored", probe_valid_o, 0);
        rd(4'd7, d); chk("R4 line address write ignored", d, 32'h40);
        chk("R4 erase strobe ignored", {busy_o, erase_done_o}, 0);
        probe(2'd0, 1'b0, 2'd0);
        chk("R5 invalidate all", {probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o},
            {10'd1, 1'b0, 4'b0000, 2'b01});
    endtask

    task automatic t_clean_flush_all();
        fill(2'd0, 1'b0, 10'd1, 2'd0, 32'h1, 1'b1);
        fill(2'd2, 1'b1, 10'd3, 2'd3, 32'h2, 1'b1);
        wr(4'd2, 32'd1); wait_idle();
        probe(2'd0, 1'b0, 2'd0); chk("R6 clean all set0", {probe_valid_o, probe_dirty_o}, {1'b1, 2'b00});
        probe(2'd2, 1'b1, 2'd0); chk("R6 clean all set2", {probe_valid_o, probe_dirty_o}, {1'b1, 2'b00});
        chk("R6 no done flag", erase_done_o, 0);
        fill(2'd3, 1'b0, 10'd4, 2'd1, 32'h3, 1'b1);
        wr(4'd4, 32'd1); wait_idle();
        probe(2'd3, 1'b0, 2'd0); chk("R7 flush all set3", {probe_valid_o, probe_uvalid_o, probe_dirty_o}, 0);
        probe(2'd0, 1'b0, 2'd0); chk("R7 flush all set0", probe_valid_o, 0);
    endtask

    task automatic t_erase();
        logic [31:0] d;
        int cnt;
        logic bad;
        fill(2'd1, 1'b1, 10'd9, 2'd2, 32'hDEAD, 1'b1);
        wr(4'd6, 32'd1);
        cnt = 0;
        while (busy_o && cnt < 20) begin
            cnt++;
            chk("R8 done low while busy", erase_done_o, 0);
            @(negedge clk_i);
        end
        chk("R3 erase busy cycles", cnt, SETS);
        chk("R8 done with idle", erase_done_o, 1);
        bad = 1'b0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int u = 0; u < 4; u++) begin
                    probe(2'(s), 1'(w), 2'(u));
                    if ({probe_tag_o, probe_valid_o, probe_uvalid_o, probe_dirty_o, probe_data_o} != 0)
                        bad = 1'b1;
                end
            end
        end
        chk("R8 everything zero", bad, 0);
        rd(4'd8, d); chk("R8 done register", d, 1);
        wr(4'd8, 32'd5); chk("R8 nonzero write keeps flag", erase_done_o, 1);
        wr(4'd8, 32'd0); chk("R8 write 0 clears flag", erase_done_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_regmap();
        t_fill();
        t_value_filter();
        t_line_ops();
        t_whole_busy();
        t_clean_flush_all();
        t_erase();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule